// File: doc/BRIEF.md
# Bit-Programmable Port with Pattern Interrupt

This block is a parallel port with no handshaking in which every pin is an input or an output on its own, chosen by a direction register. A processor-side write interface loads the output latch, the direction register, an interrupt mask and an interrupt control register. A read interface returns the port view, any of the registers, or a status word. A processor write changes only the latches of pins that are currently outputs. A read of the port returns the synchronized live level of each input pin and the latched value of each output pin. Input pins are never captured.

A pattern unit evaluates one logic function over the unmasked lines of the port view. The function can be AND, OR, NAND or NOR. Masked lines are forced to the neutral value of the function: 1 for AND and NAND, 0 for OR and NOR. An interrupt state machine turns the raw result into a level interrupt, gated by a master enable. The machine has three states. IRQ_OFF means the enable is clear. IRQ_IDLE means it is enabled and the condition is false. IRQ_ACTIVE means it is enabled and the condition holds.

The machine has these transitions. OFF→IDLE happens when enabled and there is no hit. OFF→ACTIVE happens when enabled and there is a hit. IDLE→ACTIVE happens on a hit. ACTIVE→IDLE happens when the hit ends. IDLE→OFF and ACTIVE→OFF happen when the enable clears. The interrupt output is high only in IRQ_ACTIVE.

Top module: `bitport_irq`

## Requirements
- R1: A direction bit of 1 makes the matching pin an output, and `pin_oe` equals the direction register. The direction register is written and read at address 1.
- R2: A write to address 0 changes the output latch only at bit positions whose direction bit is 1. `pin_out` shows the latch on output bits and 0 on input bits.
- R3: A read of address 0 returns the latch on output bits and the input pin level on input bits. An input change becomes visible after two rising clock edges.
- R4: The condition code sits in bits [1:0] of the control register at address 3: 0 is AND, 1 is OR, 2 is NAND, 3 is NOR. Under AND and NAND a masked line counts as 1.
- R5: Under OR and NOR a masked line counts as 0. A mask bit of 1, in the mask register at address 2, removes the line from the condition.
- R6: A write of all ones to the mask register is ignored and the previous mask is kept. It sets a sticky error flag, read as bit 1 of the status word at address 4, which stays set until reset.
- R7: Bit 2 of the control register is the master enable. `irq` is high exactly one cycle after a cycle in which the enable is set and the condition holds. Status bit 0 shows the raw condition whether or not the enable is set.
- R8: After reset, the direction register, mask, control register, output latch and error flag are all zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low clear |
| cpu_we | input | 1 | Register write strobe |
| cpu_addr | input | 3 | Register address for reads and writes |
| cpu_wdata | input | WIDTH | Write data |
| cpu_rdata | output | WIDTH | Read data for `cpu_addr` |
| pin_in | input | WIDTH | Asynchronous pin levels |
| pin_out | output | WIDTH | Pin drive values |
| pin_oe | output | WIDTH | Pin output enables |
| irq | output | 1 | Level interrupt |

## Verification
The bench uses the default parameters, an 8-bit port and a two-stage synchronizer. With these values the exact two-edge input latency and the one-edge interrupt latency can be checked cycle by cycle. With an 8-bit width, masks that split the port into halves place masked lines on both sides of the neutral value of every condition. It also makes the forbidden all-ones mask a small, specific value (0xFF) that the bench can write directly.

// File: rtl/bpio_pkg.sv
package bpio_pkg;

    typedef enum logic [1:0] {
        COND_AND  = 2'd0,
        COND_OR   = 2'd1,
        COND_NAND = 2'd2,
        COND_NOR  = 2'd3
    } cond_e;

    typedef enum logic [1:0] {
        IRQ_OFF    = 2'd0,
        IRQ_IDLE   = 2'd1,
        IRQ_ACTIVE = 2'd2
    } irq_state_e;

    localparam logic [2:0] ADDR_DATA   = 3'd0;
    localparam logic [2:0] ADDR_DIR    = 3'd1;
    localparam logic [2:0] ADDR_MASK   = 3'd2;
    localparam logic [2:0] ADDR_CTRL   = 3'd3;
    localparam logic [2:0] ADDR_STATUS = 3'd4;

endpackage

// File: rtl/bpio_sync.sv
module bpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] d_sync
);

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg[0] <= '0;
        end else begin
            stg[0] <= d_async;
        end
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg[s] <= '0;
                end else begin
                    stg[s] <= stg[s-1];
                end
            end
        end
    endgenerate

    assign d_sync = stg[STAGES-1];

endmodule

// File: rtl/bpio_pattern.sv
module bpio_pattern
    import bpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] lines,
    input  logic [WIDTH-1:0] mask,
    input  cond_e            cond,
    output logic             hit
);

    logic all_ones;
    logic any_one;

    // Masked lines are held at the neutral value of each reduction.
    assign all_ones = &(lines | mask);
    assign any_one  = |(lines & ~mask);

    always_comb begin
        unique case (cond)
            COND_AND:  hit = all_ones;
            COND_OR:   hit = any_one;
            COND_NAND: hit = ~all_ones;
            COND_NOR:  hit = ~any_one;
            default:   hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/bpio_irq_fsm.sv
module bpio_irq_fsm
    import bpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic hit,
    output logic irq
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        irq     = 1'b0;
        unique case (state_q)
            IRQ_OFF: begin
                if (enable) begin
                    state_d = hit ? IRQ_ACTIVE : IRQ_IDLE;
                end
            end
            IRQ_IDLE: begin
                if (!enable) begin
                    state_d = IRQ_OFF;
                end else if (hit) begin
                    state_d = IRQ_ACTIVE;
                end
            end
            IRQ_ACTIVE: begin
                irq = 1'b1;
                if (!enable) begin
                    state_d = IRQ_OFF;
                end else if (!hit) begin
                    state_d = IRQ_IDLE;
                end
            end
            default: begin
                state_d = IRQ_OFF;
            end
        endcase
    end

endmodule

// File: rtl/bitport_irq.sv
module bitport_irq
    import bpio_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_we,
    input  logic [2:0]       cpu_addr,
    input  logic [WIDTH-1:0] cpu_wdata,
    output logic [WIDTH-1:0] cpu_rdata,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe,
    output logic             irq
);

    localparam int CTRL_BITS = 3;
    localparam int STAT_BITS = 2;

    logic [WIDTH-1:0] dir_q;
    logic [WIDTH-1:0] out_q;
    logic [WIDTH-1:0] mask_q;
    cond_e            cond_q;
    logic             en_q;
    logic             err_q;
    logic [WIDTH-1:0] pin_s;
    logic [WIDTH-1:0] port_view;
    logic             cond_hit;
    logic             mask_bad;

    assign mask_bad = &cpu_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            out_q  <= '0;
            mask_q <= '0;
            cond_q <= COND_AND;
            en_q   <= 1'b0;
            err_q  <= 1'b0;
        end else if (cpu_we) begin
            unique case (cpu_addr)
                ADDR_DATA: out_q <= (out_q & ~dir_q) | (cpu_wdata & dir_q);
                ADDR_DIR:  dir_q <= cpu_wdata;
                ADDR_MASK: begin
                    if (mask_bad) begin
                        err_q <= 1'b1;
                    end else begin
                        mask_q <= cpu_wdata;
                    end
                end
                ADDR_CTRL: begin
                    cond_q <= cond_e'(cpu_wdata[1:0]);
                    en_q   <= cpu_wdata[2];
                end
                default: ;
            endcase
        end
    end

    bpio_sync #(
        .WIDTH (WIDTH),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .d_async(pin_in),
        .d_sync (pin_s)
    );

    assign port_view = (dir_q & out_q) | (~dir_q & pin_s);

    bpio_pattern #(
        .WIDTH(WIDTH)
    ) u_pattern (
        .lines(port_view),
        .mask (mask_q),
        .cond (cond_q),
        .hit  (cond_hit)
    );

    bpio_irq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .enable(en_q),
        .hit   (cond_hit),
        .irq   (irq)
    );

    assign pin_out = out_q & dir_q;
    assign pin_oe  = dir_q;

    always_comb begin
        unique case (cpu_addr)
            ADDR_DATA:   cpu_rdata = port_view;
            ADDR_DIR:    cpu_rdata = dir_q;
            ADDR_MASK:   cpu_rdata = mask_q;
            ADDR_CTRL:   cpu_rdata = {{(WIDTH-CTRL_BITS){1'b0}}, en_q, cond_q};
            ADDR_STATUS: cpu_rdata = {{(WIDTH-STAT_BITS){1'b0}}, err_q, cond_hit};
            default:     cpu_rdata = '0;
        endcase
    end

endmodule

// File: rtl/bitport_irq_checker.sv
module bitport_irq_checker
    import bpio_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cpu_we,
    input logic [2:0]       cpu_addr,
    input logic [WIDTH-1:0] cpu_wdata,
    input logic             irq,
    input logic             en_q,
    input logic             cond_hit,
    input logic [WIDTH-1:0] mask_q,
    input logic             err_q,
    input logic [WIDTH-1:0] out_q,
    input logic [WIDTH-1:0] dir_q
);

    AST_IRQ_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(en_q && cond_hit)); // R7

    AST_IRQ_FOLLOWS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && cond_hit) |=> irq); // R7

    AST_MASK_FF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == ADDR_MASK && (&cpu_wdata)) |=> ($stable(mask_q) && err_q)); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q); // R6

    AST_MASK_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        !(&mask_q)); // R6

    AST_INPUT_LATCH_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == ADDR_DATA)
        |=> ((out_q & ~$past(dir_q)) == ($past(out_q) & ~$past(dir_q)))); // R2

endmodule

bind bitport_irq bitport_irq_checker #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_we   (cpu_we),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .irq      (irq),
    .en_q     (en_q),
    .cond_hit (cond_hit),
    .mask_q   (mask_q),
    .err_q    (err_q),
    .out_q    (out_q),
    .dir_q    (dir_q)
);

// File: tb/tb_bitport_irq.sv
module tb_bitport_irq;

    localparam int W = 8;

    logic         clk;
    logic         rst_n;
    logic         cpu_we;
    logic [2:0]   cpu_addr;
    logic [W-1:0] cpu_wdata;
    logic [W-1:0] cpu_rdata;
    logic [W-1:0] pin_in;
    logic [W-1:0] pin_out;
    logic [W-1:0] pin_oe;
    logic         irq;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    bitport_irq #(.WIDTH(W), .SYNC_STAGES(2)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_we   (cpu_we),
        .cpu_addr (cpu_addr),
        .cpu_wdata(cpu_wdata),
        .cpu_rdata(cpu_rdata),
        .pin_in   (pin_in),
        .pin_out  (pin_out),
        .pin_oe   (pin_oe),
        .irq      (irq)
    );

    initial clk = 1'b0;
    always #2 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        @(negedge clk);
        cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [W-1:0] v);
        @(negedge clk);
        cpu_addr = a;
        #1 v = cpu_rdata;
    endtask

    task automatic set_pins(input logic [W-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        rd(3'd1, v); check("R8 dir", v, 0);
        rd(3'd2, v); check("R8 mask", v, 0);
        rd(3'd3, v); check("R8 ctrl", v, 0);
        rd(3'd4, v); check("R8 status", v, 0);
        check("R8 irq", irq, 0);
        check("R8 pin_out", pin_out, 0);
    endtask

    task automatic t_dir_data();
        logic [W-1:0] v;
        wr(3'd1, 8'h0F);
        check("R1 pin_oe", pin_oe, 8'h0F);
        rd(3'd1, v); check("R1 dir readback", v, 8'h0F);
        wr(3'd0, 8'hA5);
        check("R2 pin_out after write", pin_out, 8'h05);
        wr(3'd1, 8'hFF);
        check("R2 input-bit latches untouched", pin_out, 8'h05);
        wr(3'd1, 8'h0F);
        set_pins(8'h3C);
        rd(3'd0, v); check("R3 mixed read", v, 8'h35);
        wr(3'd1, 8'h00);
    endtask

    task automatic t_latency();
        @(negedge clk);
        cpu_addr = 3'd0;
        pin_in = 8'h5A;
        @(posedge clk);
        @(negedge clk);
        #1 check("R3 old value after one edge", cpu_rdata, 8'h3C);
        @(posedge clk);
        @(negedge clk);
        #1 check("R3 new value after two edges", cpu_rdata, 8'h5A);
    endtask

    task automatic t_and_nand();
        logic [W-1:0] v;
        wr(3'd2, 8'hF0);
        wr(3'd3, 8'h04);
        set_pins(8'h0F);
        rd(3'd4, v); check("R4 AND masked high", v[0], 1);
        check("R4 AND irq", irq, 1);
        set_pins(8'h0E);
        rd(3'd4, v); check("R4 AND one low", v[0], 0);
        check("R4 AND irq low", irq, 0);
        wr(3'd3, 8'h06);
        @(posedge clk); @(negedge clk);
        rd(3'd4, v); check("R4 NAND one low", v[0], 1);
        check("R4 NAND irq", irq, 1);
    endtask

    task automatic t_or_nor();
        logic [W-1:0] v;
        wr(3'd2, 8'h0F);
        wr(3'd3, 8'h05);
        set_pins(8'h0F);
        rd(3'd4, v); check("R5 OR masked ones neutral", v[0], 0);
        check("R5 OR irq low", irq, 0);
        set_pins(8'h20);
        rd(3'd4, v); check("R5 OR unmasked one", v[0], 1);
        check("R5 OR irq", irq, 1);
        wr(3'd3, 8'h07);
        @(posedge clk); @(negedge clk);
        check("R5 NOR irq low", irq, 0);
        set_pins(8'h0F);
        rd(3'd4, v); check("R5 NOR masked ones", v[0], 1);
        check("R5 NOR irq", irq, 1);
    endtask

    task automatic t_enable();
        logic [W-1:0] v;
        wr(3'd3, 8'h03);
        @(posedge clk); @(negedge clk);
        rd(3'd4, v); check("R7 raw status while disabled", v[0], 1);
        check("R7 irq gated off", irq, 0);
        wr(3'd3, 8'h07);
        check("R7 irq not yet", irq, 0);
        @(posedge clk); @(negedge clk);
        check("R7 irq one edge later", irq, 1);
        wr(3'd3, 8'h03);
        check("R7 irq held one edge", irq, 1);
        @(posedge clk); @(negedge clk);
        check("R7 irq dropped", irq, 0);
    endtask

    task automatic t_mask_ff();
        logic [W-1:0] v;
        wr(3'd2, 8'h0F);
        wr(3'd2, 8'hFF);
        rd(3'd2, v); check("R6 mask kept", v, 8'h0F);
        rd(3'd4, v); check("R6 error set", v[1], 1);
        wr(3'd2, 8'h03);
        rd(3'd2, v); check("R6 valid mask accepted", v, 8'h03);
        rd(3'd4, v); check("R6 error sticky", v[1], 1);
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0; pin_in = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_dir_data();
        t_latency();
        t_and_nand();
        t_or_nor();
        t_enable();
        t_mask_ff();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule